// File: doc/BRIEF.md
# AHB Slave-Port Multiplexer with Burst-Abandon IDLE Insertion

This block is the output stage in front of the two slave ports of a two-master, two-slave AHB-Lite style fabric. Each master's address phase goes to slave 0 or slave 1 according to address bit `SEL_BIT`. Each slave port is driven by the master that currently owns it. Ownership moves only on a cycle in which that slave reports ready. Master 0 wins when both masters ask for a port that is free at the same time.

The block keeps a remaining-beat counter for each master. When a master starts a four-beat incrementing burst and then issues IDLE or a new NONSEQ before all four beats have been accepted, the burst counts as abandoned. A mode input `idle_mode` chooses how the slave that was left behind learns about this. With `idle_mode` high, that slave sees one extra address phase with select high and transfer type IDLE. The port is held for that phase, and then it may pass to another master. With `idle_mode` low, the select of that slave simply drops. In the same cycle, the other master can begin a burst on the other port without any interference.

Top module: `ahb_port_mux`

## Requirements
- R1: A granted master's transfer type, address, burst and write signals appear on the addressed slave port in the same cycle, with `s_sel` high. Address bit `SEL_BIT` = 0 selects slave 0 and = 1 selects slave 1. A port that is not driven shows `s_sel` low, transfer type IDLE (2'b00) and address zero.
- R2: When both masters request a free port on a cycle in which that slave is ready, master 0 is granted and master 1 sees `m_ready` low.
- R3: A master that owns a port keeps it for as long as it keeps requesting that port. The other master waits with `m_ready` low.
- R4: While a slave's `s_ready` is low, the port is not given to a new master.
- R5: `m_ready` is high for a master that issues IDLE. For a requesting master, `m_ready` is high only when that master owns its target port and the target slave is ready.
- R6: A burst is abandoned when a master whose NONSEQ carried burst code INCR4 (3'b011) issues IDLE (2'b00) or NONSEQ (2'b10) before it has had four beats accepted, counting the NONSEQ and the following SEQ (2'b11) beats.
- R7: With `idle_mode` high, the abandoned slave sees `s_sel` high and transfer type IDLE in the address phase after the last real beat. This lasts exactly one accepted address phase.
- R8: With `idle_mode` low, the abandoned slave gets no IDLE cycle. Its `s_sel` drops unless another master is granted that port.
- R9: In the cycle one master abandons a burst, the other master's new transfer to the other slave is routed normally.
- R10: While an inserted IDLE occupies a port, a request to that port from either master stalls. It is granted in the following cycle.
- R11: A four-beat burst that completes produces no inserted IDLE.
- R12: If the abandoned slave's `s_ready` is low during the inserted IDLE, the IDLE is held until a cycle with `s_ready` high.
- R13: Out of reset no port is selected, every port shows IDLE, and both masters see `m_ready` high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_mode | input | 1 | 1: insert an IDLE on abandon, 0: drop select only |
| m_trans | input | 2x2 | Transfer type for each master |
| m_addr | input | 2xAW | Address for each master |
| m_burst | input | 2x3 | Burst code for each master |
| m_write | input | 2 | Write flag for each master |
| m_ready | output | 2 | Ready returned to each master |
| s_ready | input | 2 | Ready from each slave |
| s_sel | output | 2 | Select for each slave port |
| s_trans | output | 2x2 | Transfer type on each slave port |
| s_addr | output | 2xAW | Address on each slave port |
| s_burst | output | 2x3 | Burst code on each slave port |
| s_write | output | 2 | Write flag on each slave port |

## Verification
The assertions check the following on every cycle:
- master 0 wins a free port;
- ownership is frozen while the slave stalls;
- an owner that keeps requesting stays routed;
- no selected IDLE ever shows up in drop-select mode;
- an inserted IDLE never lasts past one accepted phase.

Some behaviour is visible only in the bench's scenarios:
- telling an abandoned burst apart from a completed one;
- the same-cycle routing of the other master to the other port;
- a request being stalled behind an inserted IDLE;
- an IDLE being stretched by a slave wait state.

// File: rtl/ahb_port_mux.sv
module ahb_port_mux #(
  parameter int AW      = 32,
  parameter int SEL_BIT = 12,
  parameter int BEATS   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_mode,
  input  logic [1:0][1:0]     m_trans,
  input  logic [1:0][AW-1:0]  m_addr,
  input  logic [1:0][2:0]     m_burst,
  input  logic [1:0]          m_write,
  output logic [1:0]          m_ready,
  input  logic [1:0]          s_ready,
  output logic [1:0]          s_sel,
  output logic [1:0][1:0]     s_trans,
  output logic [1:0][AW-1:0]  s_addr,
  output logic [1:0][2:0]     s_burst,
  output logic [1:0]          s_write
);
  localparam int CW = $clog2(BEATS + 1);
  localparam logic [1:0] T_IDLE = 2'b00, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [2:0] B_INCR4 = 3'b011;

  logic [1:0]          tgt, term, ins, gv, gid, own_v, own_id, acc, bslv;
  logic [1:0][1:0]     req;
  logic [1:0][CW-1:0]  cnt;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      tgt[i]  = m_addr[i][SEL_BIT];
      term[i] = (cnt[i] != '0) && (m_trans[i] == T_IDLE || m_trans[i] == T_NSEQ);
      for (int j = 0; j < 2; j++)
        req[i][j] = (m_trans[i] != T_IDLE) && (m_addr[i][SEL_BIT] == 1'(j));
    end
  end

  always_comb begin
    for (int j = 0; j < 2; j++) begin
      ins[j] = idle_mode && ((term[0] && bslv[0] == 1'(j)) || (term[1] && bslv[1] == 1'(j)));
      gv[j]  = 1'b0;
      gid[j] = 1'b0;
      if (ins[j]) begin
        gv[j] = 1'b0;
      end else if (own_v[j] && (req[own_id[j]][j] || !s_ready[j])) begin
        gv[j] = 1'b1; gid[j] = own_id[j];
      end else if (s_ready[j] && req[0][j]) begin
        gv[j] = 1'b1; gid[j] = 1'b0;
      end else if (s_ready[j] && req[1][j]) begin
        gv[j] = 1'b1; gid[j] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < 2; j++) begin
      s_sel[j]   = ins[j] | (gv[j] && req[gid[j]][j]);
      s_trans[j] = (s_sel[j] && !ins[j]) ? m_trans[gid[j]] : T_IDLE;
      s_addr[j]  = (s_sel[j] && !ins[j]) ? m_addr[gid[j]]  : '0;
      s_burst[j] = (s_sel[j] && !ins[j]) ? m_burst[gid[j]] : 3'b000;
      s_write[j] = s_sel[j] && !ins[j] && m_write[gid[j]];
    end
    for (int i = 0; i < 2; i++) begin
      m_ready[i] = (m_trans[i] == T_IDLE) ||
                   (gv[tgt[i]] && gid[tgt[i]] == 1'(i) && s_ready[tgt[i]]);
      acc[i]     = m_ready[i] && m_trans[i][1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v  <= '0;
      own_id <= '0;
      cnt    <= '0;
      bslv   <= '0;
    end else begin
      own_v  <= gv;
      own_id <= gid;
      for (int i = 0; i < 2; i++) begin
        if (acc[i] && m_trans[i] == T_NSEQ) begin
          cnt[i]  <= (m_burst[i] == B_INCR4) ? CW'(BEATS - 1) : '0;
          bslv[i] <= tgt[i];
        end else if (acc[i] && m_trans[i] == T_SEQ && cnt[i] != '0) begin
          cnt[i] <= cnt[i] - CW'(1);
        end else if (term[i] && s_ready[bslv[i]]) begin
          cnt[i] <= '0;
        end
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_chk
    assert_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready[j] && !own_v[j] && !ins[j] && req[0][j] && req[1][j]) |-> (m_ready[0] && !m_ready[1]))
      else $error("R2 priority broken on port %0d", j);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_v[j] && req[own_id[j]][j] && !ins[j]) |-> (s_sel[j] && s_trans[j] == m_trans[own_id[j]]))
      else $error("R3 owner lost port %0d", j);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_ready[j] && own_v[j] && !ins[j]) |=> (own_v[j] && own_id[j] == $past(own_id[j])))
      else $error("R4 owner changed while port %0d stalled", j);
    assert_one_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel[j] && s_trans[j] == T_IDLE && s_ready[j]) |=> !(s_sel[j] && s_trans[j] == T_IDLE))
      else $error("R7 inserted IDLE lasted too long on port %0d", j);
    assert_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_mode |-> !(s_sel[j] && s_trans[j] == T_IDLE))
      else $error("R8 selected IDLE in drop-select mode on port %0d", j);
  end
endmodule

// File: tb/sim_ahb_port_mux.sv
`timescale 1ns/1ps
module sim_ahb_port_mux;
  localparam logic [1:0] I = 2'b00, N = 2'b10, S = 2'b11;
  localparam logic [2:0] B4 = 3'b011, B1 = 3'b000;
  localparam logic [31:0] A0 = 32'h0000_0100, A1 = 32'h0000_1100;

  logic clk = 0, rst_n = 0, idle_mode = 1;
  logic [1:0][1:0] m_trans;
  logic [1:0][31:0] m_addr;
  logic [1:0][2:0] m_burst;
  logic [1:0] m_write, m_ready, s_ready, s_sel, s_write;
  logic [1:0][1:0] s_trans;
  logic [1:0][31:0] s_addr;
  logic [1:0][2:0] s_burst;

  ahb_port_mux u0 (.clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .m_trans(m_trans),
    .m_addr(m_addr), .m_burst(m_burst), .m_write(m_write), .m_ready(m_ready),
    .s_ready(s_ready), .s_sel(s_sel), .s_trans(s_trans), .s_addr(s_addr),
    .s_burst(s_burst), .s_write(s_write));

  always #2.5 clk = ~clk;

  typedef struct {
    string rq; logic [1:0] sel; logic [1:0] t0; logic [1:0] t1; logic [1:0] mr;
    bit ca; logic [31:0] a0; logic [31:0] a1;
  } exp_t;
  exp_t q[$];
  event smp;
  int total = 0, fails = 0;
  bit done = 0;

  always @(smp) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (s_sel !== e.sel || s_trans[0] !== e.t0 || s_trans[1] !== e.t1 || m_ready !== e.mr ||
          (e.ca && (s_addr[0] !== e.a0 || s_addr[1] !== e.a1))) begin
        fails++;
        $display("FAIL %s: sel=%b t0=%b t1=%b mr=%b a0=%h a1=%h | exp sel=%b t0=%b t1=%b mr=%b a0=%h a1=%h",
          e.rq, s_sel, s_trans[0], s_trans[1], m_ready, s_addr[0], s_addr[1],
          e.sel, e.t0, e.t1, e.mr, e.a0, e.a1);
      end
    end
  end

  task automatic cyc(input logic md, input logic [1:0] t0, input logic [31:0] a0, input logic [2:0] b0,
                     input logic [1:0] t1, input logic [31:0] a1, input logic [2:0] b1,
                     input logic [1:0] rdy, input logic [1:0] esel, input logic [1:0] e0,
                     input logic [1:0] e1, input logic [1:0] emr, input string rq,
                     input bit ca = 0, input logic [31:0] ea0 = 0, input logic [31:0] ea1 = 0);
    exp_t e;
    @(negedge clk);
    idle_mode = md;
    m_trans[0] = t0; m_addr[0] = a0; m_burst[0] = b0;
    m_trans[1] = t1; m_addr[1] = a1; m_burst[1] = b1;
    s_ready = rdy;
    e = '{rq, esel, e0, e1, emr, ca, ea0, ea1};
    q.push_back(e);
    #1 -> smp;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    m_trans = '0; m_addr = '0; m_burst = '0; m_write = 2'b01; s_ready = 2'b11;
    repeat (3) @(posedge clk);
    // R13: reset state, checked while reset is held
    cyc(1, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R13", 1, 0, 0);
    @(negedge clk) rst_n = 1;
    // R1 routing, then R6/R7/R9 abandon with concurrent start on slave 1
    cyc(1, N,A0,B4, I,0,B1, 2'b11, 2'b01, N, I, 2'b11, "R1", 1, A0, 0);
    cyc(1, S,A0+4,B4, I,0,B1, 2'b11, 2'b01, S, I, 2'b11, "R1");
    cyc(1, S,A0+8,B4, I,0,B1, 2'b11, 2'b01, S, I, 2'b11, "R1");
    cyc(1, I,0,B1, N,A1,B4, 2'b11, 2'b11, I, N, 2'b11, "R6 R7 R9", 1, 0, A1);
    cyc(1, I,0,B1, S,A1+4,B4, 2'b11, 2'b10, I, S, 2'b11, "R7");
    cyc(1, I,0,B1, S,A1+8,B4, 2'b11, 2'b10, I, S, 2'b11, "R9");
    cyc(1, I,0,B1, S,A1+12,B4, 2'b11, 2'b10, I, S, 2'b11, "R9");
    cyc(1, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R11");
    // R8 drop-select mode, abandon by NONSEQ and by IDLE
    cyc(0, N,A0,B4, I,0,B1, 2'b11, 2'b01, N, I, 2'b11, "R8");
    cyc(0, S,A0+4,B4, I,0,B1, 2'b11, 2'b01, S, I, 2'b11, "R8");
    cyc(0, N,A1,B4, I,0,B1, 2'b11, 2'b10, I, N, 2'b11, "R8 R6");
    cyc(0, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R8");
    // R10 request stalled behind an inserted IDLE
    cyc(1, N,A0,B4, I,0,B1, 2'b11, 2'b01, N, I, 2'b11, "R10");
    cyc(1, S,A0+4,B4, I,0,B1, 2'b11, 2'b01, S, I, 2'b11, "R10");
    cyc(1, I,0,B1, N,32'h200,B1, 2'b11, 2'b01, I, I, 2'b01, "R10");
    cyc(1, I,0,B1, N,32'h200,B1, 2'b11, 2'b01, N, I, 2'b11, "R10 R1", 1, 32'h200, 0);
    cyc(1, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R5");
    // R2 priority
    cyc(1, N,32'h300,B1, N,32'h340,B1, 2'b11, 2'b01, N, I, 2'b01, "R2", 1, 32'h300, 0);
    cyc(1, I,0,B1, N,32'h340,B1, 2'b11, 2'b01, N, I, 2'b11, "R2", 1, 32'h340, 0);
    // R3 ownership held through a full burst, R11 no IDLE after completion
    cyc(1, I,0,B1, N,32'h400,B4, 2'b11, 2'b01, N, I, 2'b11, "R3");
    cyc(1, N,32'h500,B1, S,32'h404,B4, 2'b11, 2'b01, S, I, 2'b10, "R3", 1, 32'h404, 0);
    cyc(1, N,32'h500,B1, S,32'h408,B4, 2'b11, 2'b01, S, I, 2'b10, "R3");
    cyc(1, N,32'h500,B1, S,32'h40C,B4, 2'b11, 2'b01, S, I, 2'b10, "R3");
    cyc(1, N,32'h500,B1, I,0,B1, 2'b11, 2'b01, N, I, 2'b11, "R11 R3", 1, 32'h500, 0);
    cyc(1, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R5");
    // R5/R12 wait states, IDLE stretched by a stalled slave
    cyc(1, N,A1,B4, I,0,B1, 2'b11, 2'b10, I, N, 2'b11, "R5");
    cyc(1, S,A1+4,B4, I,0,B1, 2'b01, 2'b10, I, S, 2'b10, "R5");
    cyc(1, S,A1+4,B4, I,0,B1, 2'b11, 2'b10, I, S, 2'b11, "R5");
    cyc(1, I,0,B1, N,32'h1200,B1, 2'b01, 2'b10, I, I, 2'b01, "R12");
    cyc(1, I,0,B1, N,32'h1200,B1, 2'b11, 2'b10, I, I, 2'b01, "R12 R7");
    cyc(1, I,0,B1, N,32'h1200,B1, 2'b11, 2'b10, I, N, 2'b11, "R12", 1, 0, 32'h1200);
    // R4 no new grant while the slave is stalled
    cyc(1, N,32'h1300,B1, I,0,B1, 2'b01, 2'b00, I, I, 2'b10, "R4");
    cyc(1, N,32'h1300,B1, I,0,B1, 2'b11, 2'b10, I, N, 2'b11, "R4", 1, 0, 32'h1300);
    cyc(1, I,0,B1, I,0,B1, 2'b11, 2'b00, I, I, 2'b11, "R13");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule